// File: doc/BRIEF.md
# Processor-Read ATM Cell Extraction Buffer

This block takes ATM cells from a byte-wide receive stream and holds complete 53-byte cells until a microprocessor reads them out one byte at a time through a small register window. A byte flagged as start-of-cell opens a new cell. The block stores a cell only after all 53 bytes have arrived, so the processor never sees part of a cell. The processor can find out that a cell is waiting in two ways. It can poll a read-only cell-available bit in the memory control register. It can also enable a per-cell interrupt and wait for the interrupt line.

After a hardware reset the buffer ignores all cell traffic until software gives the extraction memory a reset, which is a 0-to-1 transition of the extraction reset bit. From then on the buffer stays active. The same transition used later flushes the buffer. The control register also keeps the transmit-side placeholder bits so that both halves can share one register.

The register window has four locations, selected by `regAddr`:

| Address | Use |
|---|---|
| 0 | Memory control |
| 1 | Interrupt enable |
| 2 | Interrupt status |
| 3 | Cell data |

Reads are combinational in the same cycle as `regRdEn`. Any side effect of a read or write takes place at the next clock edge.

Top module: `cellExtractBuf`

## Requirements
- R1: Address 0 reads `{3'b000, extraction reset bit, cell-available, insertion reset bit, 1'b0, insertion start-of-cell bit}`. Bits 4, 2 and 0 hold the last value written to them. Bits 7:5 and bit 1 always read 0. A write to bits 7:5, 3 or 1 has no effect.
- R2: Bit 3 of address 0 (cell-available) is 1 exactly when at least one complete cell is waiting to be read. A write cannot change it.
- R3: Writing bit 4 of address 0 as 1 when it currently holds 0 flushes the extraction memory. The flush empties the buffer, discards any cell being received, and clears the pending interrupt and the overflow flag. The interrupt enable is left unchanged. Writing bit 4 as 1 when it already holds 1 does nothing.
- R4: After hardware reset, all stream bytes are ignored until the first extraction flush. After that flush the buffer accepts cells until the next hardware reset.
- R5: A cell starts at a valid byte with start-of-cell set and takes the next 52 valid bytes. Valid bytes outside a cell are ignored. A start-of-cell in the middle of a cell abandons the partial cell and starts a new one. Only a complete 53-byte cell becomes readable.
- R6: Each read of address 3 returns the next byte of the oldest waiting cell, in arrival order. The 53rd read releases that cell and updates cell-available at the same clock edge. A read when no cell is waiting returns 0 and has no effect.
- R7: The buffer holds two cells. If a start-of-cell arrives while two cells are waiting, that whole cell is dropped and the sticky overflow flag (address 2, bit 0) is set.
- R8: When a cell completes while the interrupt enable (address 1, bit 5) is 1, the sticky pending bit (address 2, bit 5) and the `irq` output are set. Several cells completing before service leave a single pending interrupt. No interrupt is raised while the enable is 0.
- R9: A read of address 2 clears the pending interrupt and the overflow flag. If a new event happens in the same cycle as that read, the event wins.
- R10: When a cell completes in the same cycle as the last byte of another cell is read, the number of waiting cells stays the same and cell-available stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low hardware reset |
| cellValid | input | 1 | Stream byte valid |
| cellSoc | input | 1 | Stream byte is the first byte of a cell |
| cellData | input | 8 | Stream byte |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe; side effects apply at the clock edge |
| regAddr | input | 2 | Register select: 0 control, 1 enable, 2 status, 3 data |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data, combinational |
| irq | output | 1 | Extraction interrupt request, active high |

## Verification
Two pairs of events can fall in the same clock edge. The first pair is the completion of an incoming cell and the release of the cell being read out. The bench provokes it by streaming a new cell while reading the 53 bytes of the single waiting cell in lock step, so the last stream byte and the last data read share a cycle. The result is judged by cell-available staying 1 and by the new cell reading back intact. The second pair is an interrupt being raised and a status read clearing it. The bench reads status on every cycle while a cell arrives, and the pending bit must survive the read that coincides with the completion.

// File: rtl/cebPkg.sv
package cebPkg;
  // Strobes from the control path to the cell memory datapath.
  typedef struct packed {
    logic wrEn;       // store one stream byte at wrIdx in the current write slot
    logic wrCommit;   // last byte of a cell: advance the write slot
    logic rdAdv;      // processor consumed one byte of the oldest cell
    logic rdRelease;  // that byte was the last: advance the read slot
    logic flush;      // extraction memory reset
  } cebStrobeT;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_IEN  = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
  localparam logic [1:0] ADDR_DATA = 2'd3;
endpackage

// File: rtl/cebDatapath.sv
module cebDatapath import cebPkg::*; #(
  parameter int CELL_BYTES = 53,
  parameter int CELLS      = 2,
  localparam int IDXW  = $clog2(CELL_BYTES),
  localparam int SLOTW = (CELLS > 1) ? $clog2(CELLS) : 1,
  localparam int AW    = $clog2(CELLS * CELL_BYTES)
) (
  input  logic            clk,
  input  logic            rstN,
  input  cebStrobeT       strb,
  input  logic [IDXW-1:0] wrIdx,
  input  logic [7:0]      wrByte,
  output logic [7:0]      rdByte,
  output logic            rdLast
);
  logic [7:0]      mem [CELLS*CELL_BYTES];
  logic [SLOTW-1:0] wrSlot, rdSlot;
  logic [IDXW-1:0]  rdIdx;
  logic [AW-1:0]    wrAddr, rdAddr;

  function automatic logic [SLOTW-1:0] nextSlot(input logic [SLOTW-1:0] s);
    return (s == SLOTW'(CELLS - 1)) ? '0 : s + 1'b1;
  endfunction

  assign wrAddr = AW'(wrSlot) * AW'(CELL_BYTES) + AW'(wrIdx);
  assign rdAddr = AW'(rdSlot) * AW'(CELL_BYTES) + AW'(rdIdx);
  assign rdByte = mem[rdAddr];
  assign rdLast = (rdIdx == IDXW'(CELL_BYTES - 1));

  always_ff @(posedge clk) begin
    if (strb.wrEn && !strb.flush) mem[wrAddr] <= wrByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrSlot <= '0;
      rdSlot <= '0;
      rdIdx  <= '0;
    end else if (strb.flush) begin
      wrSlot <= '0;
      rdSlot <= '0;
      rdIdx  <= '0;
    end else begin
      if (strb.wrCommit) wrSlot <= nextSlot(wrSlot);
      if (strb.rdRelease) begin
        rdIdx  <= '0;
        rdSlot <= nextSlot(rdSlot);
      end else if (strb.rdAdv) begin
        rdIdx <= rdIdx + 1'b1;
      end
    end
  end

  AST_FLUSH_POINTERS: assert property (@(posedge clk) disable iff (!rstN)
    strb.flush |=> (rdIdx == '0 && rdSlot == '0 && wrSlot == '0)); // R3
  AST_RELEASE_IS_READ: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdRelease |-> strb.rdAdv); // R6
  AST_COMMIT_IS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrCommit |-> (strb.wrEn && wrIdx == IDXW'(CELL_BYTES - 1))); // R5
endmodule

// File: rtl/cebCtrl.sv
module cebCtrl import cebPkg::*; #(
  parameter int CELL_BYTES = 53,
  parameter int CELLS      = 2,
  localparam int IDXW = $clog2(CELL_BYTES),
  localparam int CNTW = $clog2(CELLS + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cellValid,
  input  logic            cellSoc,
  input  logic            regWrEn,
  input  logic            regRdEn,
  input  logic [1:0]      regAddr,
  input  logic [7:0]      regWrData,
  input  logic [7:0]      memByte,
  input  logic            rdLast,
  output cebStrobeT       strb,
  output logic [IDXW-1:0] wrIdx,
  output logic [7:0]      regRdData,
  output logic            irq
);
  logic ctlB4, insRst, insSoc, armed;
  logic irqEn, irqPend, ovf;
  logic inCell, dropping;
  logic [IDXW-1:0] byteCnt;
  logic [CNTW-1:0] cellCnt;

  logic ctrlWr, ienWr, statRd, dataRd;
  logic full, avail, socOk, startCell, startDrop, midByte, endByte;
  logic unusedWr;

  assign unusedWr = ^{regWrData[7:6], regWrData[3], regWrData[1]};

  assign ctrlWr = regWrEn && regAddr == ADDR_CTRL;
  assign ienWr  = regWrEn && regAddr == ADDR_IEN;
  assign statRd = regRdEn && regAddr == ADDR_STAT;
  assign dataRd = regRdEn && regAddr == ADDR_DATA;

  assign full  = (cellCnt == CNTW'(CELLS));
  assign avail = (cellCnt != '0);

  assign strb.flush = ctrlWr && regWrData[4] && !ctlB4;

  // Start-of-cell alignment
  assign socOk     = cellValid && cellSoc && armed && !strb.flush;
  assign startCell = socOk && !full;
  assign startDrop = socOk && full;
  assign midByte   = cellValid && !cellSoc && inCell && !strb.flush;
  assign endByte   = midByte && byteCnt == IDXW'(CELL_BYTES - 1);

  assign strb.wrEn      = startCell || (midByte && !dropping);
  assign strb.wrCommit  = endByte && !dropping;
  assign strb.rdAdv     = dataRd && avail;
  assign strb.rdRelease = strb.rdAdv && rdLast;
  assign wrIdx          = cellSoc ? '0 : byteCnt;
  assign irq            = irqPend;

  always_comb begin
    unique case (regAddr)
      ADDR_CTRL: regRdData = {3'b000, ctlB4, avail, insRst, 1'b0, insSoc};
      ADDR_IEN:  regRdData = {2'b00, irqEn, 5'b00000};
      ADDR_STAT: regRdData = {2'b00, irqPend, 4'b0000, ovf};
      default:   regRdData = avail ? memByte : 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlB4  <= 1'b0;
      insRst <= 1'b0;
      insSoc <= 1'b0;
      armed  <= 1'b0;
      irqEn  <= 1'b0;
    end else begin
      if (ctrlWr) begin
        ctlB4  <= regWrData[4];
        insRst <= regWrData[2];
        insSoc <= regWrData[0];
      end
      if (strb.flush) armed <= 1'b1;
      if (ienWr) irqEn <= regWrData[5];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inCell   <= 1'b0;
      dropping <= 1'b0;
      byteCnt  <= '0;
      cellCnt  <= '0;
      irqPend  <= 1'b0;
      ovf      <= 1'b0;
    end else if (strb.flush) begin
      inCell   <= 1'b0;
      dropping <= 1'b0;
      byteCnt  <= '0;
      cellCnt  <= '0;
      irqPend  <= 1'b0;
      ovf      <= 1'b0;
    end else begin
      if (socOk) begin
        inCell   <= 1'b1;
        dropping <= full;
        byteCnt  <= IDXW'(1);
      end else if (endByte) begin
        inCell  <= 1'b0;
        byteCnt <= '0;
      end else if (midByte) begin
        byteCnt <= byteCnt + 1'b1;
      end
      cellCnt <= cellCnt + CNTW'(strb.wrCommit) - CNTW'(strb.rdRelease);
      if (strb.wrCommit && irqEn) irqPend <= 1'b1;
      else if (statRd)            irqPend <= 1'b0;
      if (startDrop)   ovf <= 1'b1;
      else if (statRd) ovf <= 1'b0;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    full |-> !strb.wrCommit); // R7
  AST_UNARMED_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    !armed |-> !strb.wrEn); // R4
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strb.flush |=> (cellCnt == '0 && !irqPend && !ovf)); // R3
  AST_FLUSH_KEEPS_EN: assert property (@(posedge clk) disable iff (!rstN)
    (strb.flush && !ienWr) |=> $stable(irqEn)); // R3
  AST_IRQ_ON_CELL: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrCommit && irqEn && !strb.flush) |=> irqPend); // R8
  AST_SWAP_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrCommit && strb.rdRelease && !strb.flush) |=> $stable(cellCnt)); // R10
endmodule

// File: rtl/cellExtractBuf.sv
module cellExtractBuf import cebPkg::*; #(
  parameter int CELL_BYTES = 53,
  parameter int CELLS      = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cellValid,
  input  logic       cellSoc,
  input  logic [7:0] cellData,
  input  logic       regWrEn,
  input  logic       regRdEn,
  input  logic [1:0] regAddr,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  output logic       irq
);
  localparam int IDXW = $clog2(CELL_BYTES);

  cebStrobeT       strb;
  logic [IDXW-1:0] wrIdx;
  logic [7:0]      memByte;
  logic            rdLast;

  cebCtrl #(.CELL_BYTES(CELL_BYTES), .CELLS(CELLS)) uCtrl (
    .clk(clk), .rstN(rstN),
    .cellValid(cellValid), .cellSoc(cellSoc),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr), .regWrData(regWrData),
    .memByte(memByte), .rdLast(rdLast),
    .strb(strb), .wrIdx(wrIdx), .regRdData(regRdData), .irq(irq)
  );

  cebDatapath #(.CELL_BYTES(CELL_BYTES), .CELLS(CELLS)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .wrIdx(wrIdx), .wrByte(cellData),
    .rdByte(memByte), .rdLast(rdLast)
  );
endmodule

// File: tb/sim_cellExtractBuf.sv
module sim_cellExtractBuf;
  localparam int NB = 53;
  localparam int NC = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cellValid = 1'b0, cellSoc = 1'b0;
  logic [7:0] cellData = '0;
  logic regWrEn = 1'b0, regRdEn = 1'b0;
  logic [1:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // Behavioural reference state
  logic [7:0] q[$];
  logic [7:0] part[$];
  bit mArmed = 0, mB4 = 0, mB2 = 0, mB0 = 0, mEn = 0, mIrq = 0, mOvf = 0;
  bit mIn = 0, mDrop = 0;
  int mCnt = 0;

  always #4 clk = ~clk;   // 125 MHz

  cellExtractBuf u0 (
    .clk(clk), .rstN(rstN), .cellValid(cellValid), .cellSoc(cellSoc), .cellData(cellData),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .irq(irq)
  );

  function automatic int waiting();
    return (q.size() + NB - 1) / NB;
  endfunction

  function automatic logic [7:0] expRead(input logic [1:0] a);
    case (a)
      2'd0: return {3'b000, mB4, (waiting() != 0), mB2, 1'b0, mB0};
      2'd1: return {2'b00, mEn, 5'b00000};
      2'd2: return {2'b00, mIrq, 4'b0000, mOvf};
      default: return (q.size() > 0) ? q[0] : 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed * 37 + i * 5 + 3) & 255);
  endfunction

  task automatic check(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%02h expected=%02h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic v, input logic s, input logic [7:0] d,
                     input logic we, input logic re, input logic [1:0] a,
                     input logic [7:0] wd, input string tag);
    int oldCnt;
    bit oldEn, fl;
    cellValid = v; cellSoc = s; cellData = d;
    regWrEn = we; regRdEn = re; regAddr = a; regWrData = wd;
    #2;
    if (re) check(tag, "read data", regRdData, expRead(a));
    check(tag, "irq", {7'b0, irq}, {7'b0, mIrq});
    @(posedge clk);
    oldCnt = waiting();
    oldEn = mEn;
    fl = we && a == 2'd0 && wd[4] && !mB4;
    if (re && a == 2'd3 && q.size() > 0) void'(q.pop_front());
    if (re && a == 2'd2) begin mIrq = 0; mOvf = 0; end
    if (!fl && v) begin
      if (s) begin
        if (mArmed) begin
          mIn = 1; mCnt = 1;
          if (oldCnt == NC) begin mDrop = 1; mOvf = 1; end
          else begin mDrop = 0; part.delete(); part.push_back(d); end
        end
      end else if (mIn) begin
        if (!mDrop) part.push_back(d);
        if (mCnt == NB - 1) begin
          mIn = 0;
          if (!mDrop) begin
            foreach (part[k]) q.push_back(part[k]);
            if (oldEn) mIrq = 1;
          end
        end else mCnt++;
      end
    end
    if (we && a == 2'd0) begin mB4 = wd[4]; mB2 = wd[2]; mB0 = wd[0]; end
    if (we && a == 2'd1) mEn = wd[5];
    if (fl) begin
      mArmed = 1; q.delete(); part.delete(); mIn = 0; mDrop = 0; mIrq = 0; mOvf = 0;
    end
    #1;
  endtask

  task automatic idle(input string tag);
    cyc(0, 0, 8'h00, 0, 0, 2'd0, 8'h00, tag);
  endtask
  task automatic wreg(input logic [1:0] a, input logic [7:0] d, input string tag);
    cyc(0, 0, 8'h00, 1, 0, a, d, tag);
  endtask
  task automatic rreg(input logic [1:0] a, input string tag);
    cyc(0, 0, 8'h00, 0, 1, a, 8'h00, tag);
  endtask
  task automatic sendBytes(input int seed, input int from, input int upto, input string tag);
    for (int i = from; i < upto; i++) cyc(1, i == 0, pat(seed, i), 0, 0, 2'd0, 8'h00, tag);
  endtask
  task automatic readCell(input string tag);
    for (int i = 0; i < NB; i++) rreg(2'd3, tag);
  endtask
  task automatic sendAndRead(input int seed, input logic [1:0] a, input string tag);
    for (int i = 0; i < NB; i++) cyc(1, i == 0, pat(seed, i), 0, 1, a, 8'h00, tag);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // Reset state of every register
    rreg(2'd0, "R1"); rreg(2'd1, "R1"); rreg(2'd2, "R8"); rreg(2'd3, "R6");
    // Traffic before the first flush is ignored
    sendBytes(1, 0, NB, "R4");
    rreg(2'd0, "R4"); rreg(2'd3, "R4");
    // Rising edge of bit 4 arms and flushes
    wreg(2'd0, 8'h10, "R3");
    rreg(2'd0, "R1");
    // Bit 4 already 1: no flush; bits 7:5, 3, 1 ignored; 2 and 0 kept
    wreg(2'd0, 8'hFF, "R1"); rreg(2'd0, "R1");
    wreg(2'd0, 8'h10, "R1"); rreg(2'd0, "R2");
    // Stray bytes outside a cell
    for (int i = 0; i < 5; i++) cyc(1, 0, 8'hA5, 0, 0, 2'd0, 8'h00, "R5");
    rreg(2'd0, "R5");
    // One cell, polled and read out
    sendBytes(2, 0, NB, "R2");
    rreg(2'd0, "R2");
    readCell("R6");
    rreg(2'd0, "R2");
    rreg(2'd3, "R6");
    // Interrupt: two cells leave one pending interrupt
    wreg(2'd1, 8'h20, "R8");
    sendBytes(3, 0, NB, "R8");
    idle("R8");
    sendBytes(4, 0, NB, "R8");
    rreg(2'd2, "R8"); rreg(2'd2, "R9");
    // Full buffer drops a cell whole
    sendBytes(5, 0, NB, "R7");
    rreg(2'd0, "R7"); rreg(2'd2, "R7"); rreg(2'd2, "R9");
    readCell("R6");
    // Release and completion in the same cycle
    sendAndRead(6, 2'd3, "R10");
    rreg(2'd0, "R10");
    readCell("R10");
    rreg(2'd2, "R9");
    // Status read every cycle while a cell completes
    sendAndRead(7, 2'd2, "R9");
    rreg(2'd2, "R9");
    // SoC in the middle of a cell restarts alignment
    sendBytes(8, 0, 20, "R5");
    sendBytes(9, 0, NB, "R5");
    rreg(2'd0, "R5");
    // Level 1 on bit 4 does not flush; 0 then 1 does
    wreg(2'd0, 8'h10, "R3"); rreg(2'd0, "R3");
    wreg(2'd0, 8'h00, "R3"); wreg(2'd0, 8'h10, "R3");
    rreg(2'd0, "R3"); rreg(2'd1, "R3"); rreg(2'd2, "R3"); rreg(2'd3, "R3");
    // Flush during a partial cell discards it
    sendBytes(10, 0, 20, "R3");
    wreg(2'd0, 8'h00, "R3"); wreg(2'd0, 8'h10, "R3");
    sendBytes(10, 20, NB, "R3");
    rreg(2'd0, "R3");
    // Interrupt disabled: cell arrives without interrupt
    wreg(2'd1, 8'h00, "R8");
    sendBytes(11, 0, NB, "R8");
    idle("R8");
    rreg(2'd2, "R8"); rreg(2'd0, "R2");
    readCell("R6");
    rreg(2'd0, "R2");
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule